// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O unit with 128 pins grouped into four banks of 32. A simple register bus (byte offset, write enable, write data, registered read data) reaches a per-bank direction word, an output-state word, rising and falling edge-enable words and two alternate-function words. The output state is never written directly: software ORs bits in through a write-only set register and removes them through a write-only clear register. The block drives the pad output and output-enable vectors and brings the external pins in through a two-flop synchronizer.

The edge-enable words are forwarded to a separate edge-detection block. Its status vector is read back through this block's map, and a write to a status word is passed on as a one-cycle clear pulse. The alternate-function words are plain storage for software. The map has an irregular layout: banks 0 to 2 use consecutive words in the low region, bank 3 sits in a window 0x100 higher, and the alternate-function pairs form their own run.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it falls, every direction, output-state, edge-enable and alternate-function word is zero, so `pin_oe`, `pin_out`, `rise_en`, `fall_en`, `edge_clear` and `bus_rdata` are all zero.
- R2: A write to a bank's set register (bank 0/1/2 at 0x018/0x01C/0x020, bank 3 at 0x118) ORs the data into that bank's output state, and the state is visible on `pin_out` the cycle after the write.
- R3: A write to a bank's clear register (0x024/0x028/0x02C/0x124) clears every output-state bit that is 1 in the written data and leaves the other bits unchanged.
- R4: The set and clear registers always read as zero.
- R5: Direction words (0x00C/0x010/0x014/0x10C) are read/write. Bit value 1 makes the pin an output: `pin_oe` equals the direction vector, and `pin_out` is high only where direction and output state are both 1. A direction change re-evaluates every pin of the bank in the same cycle.
- R6: The level register (0x000/0x004/0x008/0x100) returns the output state on output pins and the synchronized input on input pins.
- R7: Rising-enable words (0x030/0x034/0x038/0x130) and falling-enable words (0x03C/0x040/0x044/0x13C) are read/write and appear on `rise_en` and `fall_en`, bank n on bits 32n+31..32n.
- R8: Alternate-function words are read/write storage: the low word of bank n at 0x054+8n and the high word at 0x058+8n.
- R9: Edge status words (0x048/0x04C/0x050/0x148) read the matching slice of `edge_status`. A write to one drives the written data on that bank's slice of `edge_clear` for exactly the one cycle after the write, with zero on every other slice.
- R10: Any offset at or above 0x200, any offset that is not a multiple of 4, and any other unmapped offset reads as zero and ignores writes.
- R11: `bus_rdata` presents the register selected by `bus_addr` at the rising edge after the address is applied (one cycle of latency).
- R12: A change on `pin_in` reaches the level register only after two synchronizer stages, so it is first visible in `bus_rdata` three clock edges after the change.
- R13: Bank 3 registers are reached only through the high window (level 0x100, direction 0x10C and so on), and they control pins 127 down to 96.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write enable for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's offset |
| pin_in | input | 128 | External pin levels (asynchronous) |
| pin_out | output | 128 | Driven pin levels (output state AND direction) |
| pin_oe | output | 128 | Pin output enables (direction) |
| rise_en | output | 128 | Rising-edge enables to the edge block |
| fall_en | output | 128 | Falling-edge enables to the edge block |
| edge_status | input | 128 | Edge status from the edge block |
| edge_clear | output | 128 | One-cycle clear pulse to the edge block |

## Verification
The bench uses the default build: 32-bit banks, a 12-bit offset and two synchronizer stages. The 12-bit offset lets writes at 0x200 and 0x30C stand as aliases of real registers, so a decoder that drops the upper offset bits is caught. Two stages keep the synchronizer delay short enough to count edge by edge. With the full 4 by 32 width, the bank 3 window is reached both through the map and at the top pin slice.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W     = 32;
    localparam int NUM_BANKS  = 4;
    localparam int ADDR_W     = 12;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int PINS       = NUM_BANKS * BANK_W;
    localparam int WORD_IDX_W = ADDR_W - 2;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_STAT,
        RK_ALT_LO,
        RK_ALT_HI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } reg_sel_t;

    // Order of the register groups inside one bank stride (3 words per group)
    function automatic reg_kind_e group_kind(input logic [WORD_IDX_W-1:0] grp);
        case (grp)
            WORD_IDX_W'(0): return RK_LEVEL;
            WORD_IDX_W'(1): return RK_DIR;
            WORD_IDX_W'(2): return RK_SET;
            WORD_IDX_W'(3): return RK_CLR;
            WORD_IDX_W'(4): return RK_RISE;
            WORD_IDX_W'(5): return RK_FALL;
            WORD_IDX_W'(6): return RK_STAT;
            default:        return RK_NONE;
        endcase
    endfunction

    // Offset decode: low region groups of three banks, alternate-function
    // pairs, and a high window at +0x100 carrying bank 3 (R10, R13)
    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_t                r;
        logic [WORD_IDX_W-1:0]   w;
        logic [WORD_IDX_W-1:0]   d;
        logic [WORD_IDX_W-1:0]   q;
        logic [WORD_IDX_W-1:0]   m;
        r.kind = RK_NONE;
        r.bank = '0;
        w = a[ADDR_W-1:2];
        d = '0;
        q = '0;
        m = '0;
        if (a < ADDR_W'(12'h200) && a[1:0] == 2'b00) begin
            if (w >= WORD_IDX_W'(21) && w <= WORD_IDX_W'(28)) begin
                d      = w - WORD_IDX_W'(21);
                r.bank = d[2:1];
                r.kind = d[0] ? RK_ALT_HI : RK_ALT_LO;
            end else if (w < WORD_IDX_W'(21)) begin
                q      = w / WORD_IDX_W'(3);
                m      = w - q * WORD_IDX_W'(3);
                r.kind = group_kind(q);
                r.bank = m[BANK_IDX_W-1:0];
            end else if (w >= WORD_IDX_W'(64) && w < WORD_IDX_W'(85)) begin
                d = w - WORD_IDX_W'(64);
                q = d / WORD_IDX_W'(3);
                m = d - q * WORD_IDX_W'(3);
                if (m == '0) begin
                    r.kind = group_kind(q);
                    r.bank = BANK_IDX_W'(NUM_BANKS - 1);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 128,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // R12: chain of STAGES flops ahead of the level register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         hit,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] stat_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] drive,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] clr_pulse,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] out_q;
    logic [W-1:0] alt_lo_q;
    logic [W-1:0] alt_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin                      // R1
            dir_q     <= '0;
            out_q     <= '0;
            rise_q    <= '0;
            fall_q    <= '0;
            alt_lo_q  <= '0;
            alt_hi_q  <= '0;
            clr_pulse <= '0;
        end else begin
            clr_pulse <= '0;
            if (we && hit) begin
                case (kind)
                    RK_DIR:    dir_q     <= wdata;            // R5
                    RK_SET:    out_q     <= out_q | wdata;    // R2
                    RK_CLR:    out_q     <= out_q & ~wdata;   // R3
                    RK_RISE:   rise_q    <= wdata;            // R7
                    RK_FALL:   fall_q    <= wdata;
                    RK_ALT_LO: alt_lo_q  <= wdata;            // R8
                    RK_ALT_HI: alt_hi_q  <= wdata;
                    RK_STAT:   clr_pulse <= wdata;            // R9
                    default:   ;
                endcase
            end
        end
    end

    assign drive = out_q & dir_q;

    always_comb begin
        case (kind)
            RK_LEVEL:  rd_val = drive | (pin_sync & ~dir_q);  // R6
            RK_DIR:    rd_val = dir_q;
            RK_RISE:   rd_val = rise_q;
            RK_FALL:   rd_val = fall_q;
            RK_ALT_LO: rd_val = alt_lo_q;
            RK_ALT_HI: rd_val = alt_hi_q;
            RK_STAT:   rd_val = stat_in;
            default:   rd_val = '0;                            // R4, R10
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   rise_en,
    output logic [PINS-1:0]   fall_en,
    input  logic [PINS-1:0]   edge_status,
    output logic [PINS-1:0]   edge_clear
);
    reg_sel_t          sel;
    logic [PINS-1:0]   pin_sync;
    logic [BANK_W-1:0] bank_rd [NUM_BANKS];

    assign sel = decode_offset(bus_addr);

    gpio_pin_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank_regs #(.W(BANK_W)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .we        (bus_we),
            .hit       (sel.bank == BANK_IDX_W'(b)),
            .kind      (sel.kind),
            .wdata     (bus_wdata),
            .pin_sync  (pin_sync[b*BANK_W +: BANK_W]),
            .stat_in   (edge_status[b*BANK_W +: BANK_W]),
            .dir_q     (pin_oe[b*BANK_W +: BANK_W]),
            .drive     (pin_out[b*BANK_W +: BANK_W]),
            .rise_q    (rise_en[b*BANK_W +: BANK_W]),
            .fall_q    (fall_en[b*BANK_W +: BANK_W]),
            .clr_pulse (edge_clear[b*BANK_W +: BANK_W]),
            .rd_val    (bank_rd[b])
        );
    end

    // R11: one registered read stage
    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= bank_rd[sel.bank];
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BANK_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   rise_en,
    input logic [PINS-1:0]   fall_en,
    input logic [PINS-1:0]   edge_clear
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && rise_en == '0 &&
                 fall_en == '0 && edge_clear == '0 && bus_rdata == '0));

    p_drive_needs_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    p_setclr_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 12'h018 || bus_addr == 12'h124) |=> bus_rdata == '0);

    p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= 12'h200) |=> bus_rdata == '0);

    p_unmapped_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr >= 12'h200) |=>
            ($stable(pin_oe) && $stable(pin_out) && $stable(rise_en) && $stable(fall_en)));

    p_clear_needs_write_r9: assert property (@(posedge clk) disable iff (rst)
        (edge_clear != '0) |-> $past(bus_we));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (.*);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [127:0]  pin_in = '0;
    logic [127:0]  pin_out, pin_oe, rise_en, fall_en, edge_clear;
    logic [127:0]  edge_status = '0;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rise_en(rise_en),
        .fall_en(fall_en), .edge_status(edge_status), .edge_clear(edge_clear)
    );

    // Offsets computed from the stated map: kinds 0..6 = level, dir, set,
    // clear, rise, fall, status; banks 0..2 in stride 4, bank 3 at +0x100
    function automatic logic [11:0] off(input int kind, input int bank);
        logic [11:0] base;
        base = 12'(kind * 12);
        return (bank < 3) ? base + 12'(bank * 4) : base + 12'h100;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        @(posedge clk); @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 rise/fall", rise_en | fall_en, '0);
        chk("R1 edge_clear", edge_clear, '0);
        chk("R1 rdata", 128'(bus_rdata), '0);
        rd(off(1, 2), v);         chk("R1 dir bank2", 128'(v), '0);
        rd(12'h070, v);           chk("R1 alt hi bank3", 128'(v), '0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(off(1, 1), 32'hFFFF_FFFF);
        wr(off(2, 1), 32'hA5A5_0000);
        chk("R2 set first", 128'(pin_out[63:32]), 128'h A5A5_0000);
        wr(off(2, 1), 32'h0000_00FF);
        chk("R2 set ORs", 128'(pin_out[63:32]), 128'h A5A5_00FF);
        wr(off(3, 1), 32'h0500_000F);
        chk("R3 clear", 128'(pin_out[63:32]), 128'h A0A5_00F0);
        rd(off(2, 1), v);         chk("R4 set reads zero", 128'(v), '0);
        rd(off(3, 1), v);         chk("R4 clear reads zero", 128'(v), '0);
        rd(off(0, 1), v);         chk("R6 level all outputs", 128'(v), 128'h A0A5_00F0);
    endtask

    task automatic t_direction();
        logic [31:0] v;
        wr(off(2, 0), 32'hF0F0_F0F0);
        chk("R5 no drive while input", 128'(pin_out[31:0]), '0);
        wr(off(1, 0), 32'hFF00_FF00);
        chk("R5 oe follows dir", 128'(pin_oe[31:0]), 128'h FF00_FF00);
        chk("R5 drive reevaluated", 128'(pin_out[31:0]), 128'h F000_F000);
        rd(off(1, 0), v);         chk("R5 dir readback", 128'(v), 128'h FF00_FF00);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in[95:64] = 32'h1357_9BDF;
        wr(off(1, 2), 32'h0000_FFFF);
        wr(off(2, 2), 32'h1234_5678);
        repeat (3) @(negedge clk);
        rd(off(0, 2), v);         chk("R6 level mix", 128'(v), 128'h 1357_5678);
    endtask

    task automatic t_sync();
        pin_in[127:96] = 32'hCAFE_F00D;
        bus_addr = off(0, 3);
        @(posedge clk); @(negedge clk);
        chk("R12 after one edge", 128'(bus_rdata), '0);
        @(posedge clk); @(negedge clk);
        chk("R12 after two edges", 128'(bus_rdata), '0);
        @(posedge clk); @(negedge clk);
        chk("R12 after three edges", 128'(bus_rdata), 128'h CAFE_F00D);
    endtask

    task automatic t_latency();
        bus_addr = off(1, 1);
        #1;
        chk("R11 not before edge", 128'(bus_rdata), 128'h CAFE_F00D);
        @(posedge clk); @(negedge clk);
        chk("R11 one edge", 128'(bus_rdata), 128'h FFFF_FFFF);
        bus_addr = off(1, 0);
        @(posedge clk); @(negedge clk);
        chk("R11 next address", 128'(bus_rdata), 128'h FF00_FF00);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(off(4, 3), 32'h8000_0001);
        wr(off(5, 0), 32'h0000_FF00);
        wr(off(4, 1), 32'h1234_0000);
        chk("R7 rise_en", rise_en, {32'h8000_0001, 32'h0, 32'h1234_0000, 32'h0});
        chk("R7 fall_en", fall_en, {96'h0, 32'h0000_FF00});
        rd(off(4, 3), v);         chk("R7 rise bank3 readback", 128'(v), 128'h 8000_0001);
        rd(off(5, 0), v);         chk("R7 fall bank0 readback", 128'(v), 128'h 0000_FF00);
        wr(off(1, 3), 32'h0000_00F0);
        wr(off(2, 3), 32'h0000_0030);
        chk("R13 bank3 oe", pin_oe[127:96], 32'h0000_00F0);
        chk("R13 bank3 out", pin_out[127:96], 32'h0000_0030);
        rd(off(0, 3), v);         chk("R13 bank3 level", 128'(v), 128'h CAFE_F03D);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        for (int b = 0; b < 4; b++) begin
            wr(12'(12'h054 + 8 * b), 32'h1111_0000 + 32'(b));
            wr(12'(12'h058 + 8 * b), 32'h2222_0000 + 32'(b));
        end
        for (int b = 0; b < 4; b++) begin
            rd(12'(12'h054 + 8 * b), v); chk("R8 alt low", 128'(v), 128'(32'h1111_0000 + 32'(b)));
            rd(12'(12'h058 + 8 * b), v); chk("R8 alt high", 128'(v), 128'(32'h2222_0000 + 32'(b)));
        end
    endtask

    task automatic t_status();
        logic [31:0] v;
        edge_status = {32'hAAAA_0003, 32'h5555_0002, 32'h0000_0001, 32'hDEAD_0000};
        rd(off(6, 2), v);         chk("R9 status bank2", 128'(v), 128'h 5555_0002);
        rd(off(6, 3), v);         chk("R9 status bank3", 128'(v), 128'h AAAA_0003);
        wr(off(6, 3), 32'h0000_0F0F);
        chk("R9 clear pulse", edge_clear, {32'h0000_0F0F, 96'h0});
        @(posedge clk); @(negedge clk);
        chk("R9 pulse one cycle", edge_clear, '0);
        wr(off(6, 1), 32'h0000_0001);
        chk("R9 clear bank1", edge_clear, {64'h0, 32'h1, 32'h0});
    endtask

    task automatic t_unmapped();
        logic [31:0]  v;
        logic [127:0] oe0, out0, re0, fe0;
        oe0 = pin_oe; out0 = pin_out; re0 = rise_en; fe0 = fall_en;
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h30C, 32'hFFFF_FFFF);
        wr(12'h074, 32'hFFFF_FFFF);
        wr(12'h00E, 32'hFFFF_FFFF);
        wr(12'h134, 32'hFFFF_FFFF);
        wr(12'h218, 32'hFFFF_FFFF);
        chk("R10 oe unchanged", pin_oe, oe0);
        chk("R10 out unchanged", pin_out, out0);
        chk("R10 enables unchanged", {rise_en ^ re0} | {fall_en ^ fe0}, '0);
        rd(12'h200, v);           chk("R10 read 0x200", 128'(v), '0);
        rd(12'h30C, v);           chk("R10 read 0x30C", 128'(v), '0);
        rd(12'h00E, v);           chk("R10 read misaligned", 128'(v), '0);
        rd(12'h14C, v);           chk("R10 read hole", 128'(v), '0);
        rd(12'h074, v);           chk("R10 read after alt", 128'(v), '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_direction();
        t_level();
        t_sync();
        t_latency();
        t_enables();
        t_alt();
        t_status();
        t_unmapped();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule